// File: doc/BRIEF.md
# Multi-Sector NOR Flash Erase Sequencer

This block runs a complete erase of one or more consecutive sectors on a byte-wide NOR flash device. A host raises `start` for one cycle with a first sector number and a sector count. The block then drives the device port through three phases. First it sends the reset and unlock preamble. Next it queues every sector, back to back, while the device is still collecting them. Last it polls the device status byte until it can classify the outcome.

While it queues sectors, the block reads each newly added sector address back. This read confirms that the device's collection timer has not already closed. Completion is decided from the three most recent status reads. The result is a one-cycle `done` pulse together with an error flag and a cause code. Both stay valid until the next accepted start. The device port is a plain synchronous interface. A write happens in any cycle with `fl_we` high. Read data on `fl_rdata` belongs to the cycle in which `fl_re` is high and is sampled at the end of that cycle.

Top module: `nor_multi_erase`

## Requirements
- R1: In the six cycles after an accepted start, the block writes these (address, data) pairs in order: (0x555,0xF0), (0x555,0xAA), (0x2AA,0x55), (0x555,0x80), (0x555,0xAA), (0x2AA,0x55). No cycle asserts `fl_we` and `fl_re` together.
- R2: Sector commands write data 0x30 to address `sector << SECT_BITS`. They cover the sectors from `start_sector` upward, one per sector counted. The first of them is issued in cycle 7.
- R3: Each sector command other than the first is followed in the next cycle by a read of that same sector address. If bit 3 of that read is set, the block ends with `err`=1 and `err_cause`=1 and issues no further sector command.
- R4: Two consecutive sector commands are never more than two cycles apart, which stays below the window limit `WIN_CYC`.
- R5: Polling reads the first sector's address once per cycle. The first two reads only fill the history. A read whose bit 7 is clear and which differs from the previous read means the erase is still running.
- R6: If the newest read equals the previous one, the block ends with `err`=1. The cause is 2 if bit 5 of the read two before the newest is set, and 3 otherwise. This holds even when bit 7 is set.
- R7: If the newest read differs from the previous one and has bit 7 set, the block ends with `err`=0 and `err_cause`=0.
- R8: If `POLL_MAX` status reads bring no verdict, the block ends with `err`=1 and `err_cause`=4.
- R9: `done` is a one-cycle pulse. `busy` is high from the cycle after an accepted start until `done`. A `start` raised while busy is ignored. `err` and `err_cause` hold their values until the next accepted start.
- R10: Under reset and after it, `busy`, `done`, `err`, `err_cause`, `fl_we` and `fl_re` are all zero.
- R11: With N sectors, `done` rises at the edge 6+2N+d after the start edge, where d is the zero-based index of the deciding poll read. An abort at sector index j (0-based) raises `done` at edge 7+2j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an erase (accepted only when idle) |
| start_sector | input | SECT_W | First sector number |
| sector_count | input | CNT_W | Number of sectors (0 treated as 1) |
| busy | output | 1 | Erase in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 1 | Operation failed |
| err_cause | output | 3 | 0 none, 1 window closed, 2 device fault, 3 stalled, 4 poll timeout |
| fl_addr | output | SECT_W+SECT_BITS | Flash address |
| fl_wdata | output | 8 | Flash write data |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_rdata | input | 8 | Flash read data, valid in the cycle of `fl_re` |

## Verification
Every result of this block has a fixed due edge once the sector count, the abort sector or the deciding poll index is known. The bench computes that edge from R11: 6+2N+d for a verdict, 7+2j for a window abort, and 8+POLL_MAX-1 for a timeout. It counts edges from the start edge and samples a few nanoseconds after each edge, so a pulse that arrives one edge early or late is flagged. The bench model logs every bus cycle at the edge that completes it. The whole transaction list, including the check reads and each poll read, is compared with the list the requirements predict. The cycle after `done` is then sampled to confirm that the pulse has dropped while the error code holds.

// File: rtl/erase_pkg.sv
package erase_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_SECT,
        PH_CHECK,
        PH_POLL
    } phase_t;

    typedef enum logic [2:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_WINDOW  = 3'd1,
        CAUSE_DEVICE  = 3'd2,
        CAUSE_STALL   = 3'd3,
        CAUSE_TIMEOUT = 3'd4
    } cause_t;

    typedef enum logic [1:0] {
        VD_RUNNING,
        VD_COMPLETE,
        VD_DEVFAIL,
        VD_STALL
    } verdict_t;

    typedef struct packed {
        logic [10:0] addr;
        logic [7:0]  data;
    } bus_word_t;

    localparam int        SETUP_LEN  = 6;
    localparam logic [7:0] SECTOR_CMD = 8'h30;
    localparam int        DONE_BIT   = 7;
    localparam int        FAULT_BIT  = 5;
    localparam int        TIMER_BIT  = 3;

    function automatic bus_word_t setup_word(input logic [2:0] step);
        case (step)
            3'd0:    return '{addr: 11'h555, data: 8'hF0};
            3'd1:    return '{addr: 11'h555, data: 8'hAA};
            3'd2:    return '{addr: 11'h2AA, data: 8'h55};
            3'd3:    return '{addr: 11'h555, data: 8'h80};
            3'd4:    return '{addr: 11'h555, data: 8'hAA};
            default: return '{addr: 11'h2AA, data: 8'h55};
        endcase
    endfunction

endpackage

// File: rtl/erase_bus_drive.sv
module erase_bus_drive
    import erase_pkg::*;
#(
    parameter int SECT_W    = 4,
    parameter int SECT_BITS = 12,
    localparam int ADDR_W   = SECT_W + SECT_BITS
) (
    input  phase_t              phase,
    input  logic [2:0]          step,
    input  logic [SECT_W-1:0]   cur_sect,
    input  logic [SECT_W-1:0]   poll_sect,
    output logic [ADDR_W-1:0]   fl_addr,
    output logic [7:0]          fl_wdata,
    output logic                fl_we,
    output logic                fl_re
);
    bus_word_t word;

    always_comb begin
        word     = setup_word(step);
        fl_addr  = '0;
        fl_wdata = '0;
        fl_we    = 1'b0;
        fl_re    = 1'b0;
        case (phase)
            PH_SETUP: begin
                fl_we    = 1'b1;
                fl_addr  = ADDR_W'(word.addr);
                fl_wdata = word.data;
            end
            PH_SECT: begin
                fl_we    = 1'b1;
                fl_addr  = {cur_sect, {SECT_BITS{1'b0}}};
                fl_wdata = SECTOR_CMD;
            end
            PH_CHECK: begin
                fl_re    = 1'b1;
                fl_addr  = {cur_sect, {SECT_BITS{1'b0}}};
            end
            PH_POLL: begin
                fl_re    = 1'b1;
                fl_addr  = {poll_sect, {SECT_BITS{1'b0}}};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/erase_status_judge.sv
module erase_status_judge
    import erase_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       sample,
    input  logic [7:0] rdata,
    output verdict_t   verdict
);
    logic [7:0] newest_q;
    logic [7:0] older_q;
    logic [1:0] fill_q;

    always_comb begin
        verdict = VD_RUNNING;
        if (sample && fill_q == 2'd2) begin
            if (!rdata[DONE_BIT] && rdata != newest_q)
                verdict = VD_RUNNING;
            else if (rdata == newest_q)
                verdict = older_q[FAULT_BIT] ? VD_DEVFAIL : VD_STALL;
            else
                verdict = VD_COMPLETE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            newest_q <= '0;
            older_q  <= '0;
            fill_q   <= '0;
        end else if (sample) begin
            older_q  <= newest_q;
            newest_q <= rdata;
            if (fill_q != 2'd2)
                fill_q <= fill_q + 2'd1;
        end
    end

    // R5: no verdict before two earlier reads are held
    AST_HISTORY_FIRST: assert property (@(posedge clk) disable iff (rst)
        (verdict != VD_RUNNING) |-> (fill_q == 2'd2 && sample)); // R5
endmodule

// File: rtl/nor_multi_erase.sv
module nor_multi_erase
    import erase_pkg::*;
#(
    parameter int SECT_W    = 4,
    parameter int SECT_BITS = 12,
    parameter int CNT_W     = 5,
    parameter int WIN_CYC   = 2500,
    parameter int POLL_MAX  = 100000,
    localparam int ADDR_W   = SECT_W + SECT_BITS,
    localparam int WIN_W    = $clog2(WIN_CYC + 1),
    localparam int POLL_W   = $clog2(POLL_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [SECT_W-1:0] start_sector,
    input  logic [CNT_W-1:0]  sector_count,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [2:0]        err_cause,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_wdata,
    output logic              fl_we,
    output logic              fl_re,
    input  logic [7:0]        fl_rdata
);
    phase_t             phase;
    logic [2:0]         step;
    logic [SECT_W-1:0]  cur_sect;
    logic [SECT_W-1:0]  poll_sect;
    logic [CNT_W-1:0]   left;
    logic               first;
    logic [POLL_W-1:0]  poll_cnt;
    logic [WIN_W-1:0]   win_cnt;
    verdict_t           verdict;
    logic               accept;

    assign busy   = (phase != PH_IDLE);
    assign accept = (phase == PH_IDLE) && start;

    erase_bus_drive #(.SECT_W(SECT_W), .SECT_BITS(SECT_BITS)) u_drive (
        .phase     (phase),
        .step      (step),
        .cur_sect  (cur_sect),
        .poll_sect (poll_sect),
        .fl_addr   (fl_addr),
        .fl_wdata  (fl_wdata),
        .fl_we     (fl_we),
        .fl_re     (fl_re)
    );

    erase_status_judge u_judge (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .sample  (phase == PH_POLL),
        .rdata   (fl_rdata),
        .verdict (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            step      <= '0;
            cur_sect  <= '0;
            poll_sect <= '0;
            left      <= '0;
            first     <= 1'b0;
            poll_cnt  <= '0;
            done      <= 1'b0;
            err       <= 1'b0;
            err_cause <= CAUSE_NONE;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: if (start) begin
                    phase     <= PH_SETUP;
                    step      <= '0;
                    cur_sect  <= start_sector;
                    poll_sect <= start_sector;
                    left      <= (sector_count == '0) ? '0 : sector_count - 1'b1;
                    first     <= 1'b1;
                    poll_cnt  <= '0;
                    err       <= 1'b0;
                    err_cause <= CAUSE_NONE;
                end
                PH_SETUP: begin
                    if (step == 3'(SETUP_LEN - 1))
                        phase <= PH_SECT;
                    else
                        step <= step + 3'd1;
                end
                PH_SECT: begin
                    first <= 1'b0;
                    if (!first)
                        phase <= PH_CHECK;
                    else if (left == '0)
                        phase <= PH_POLL;
                    else begin
                        cur_sect <= cur_sect + 1'b1;
                        left     <= left - 1'b1;
                    end
                end
                PH_CHECK: begin
                    if (fl_rdata[TIMER_BIT]) begin
                        phase     <= PH_IDLE;
                        done      <= 1'b1;
                        err       <= 1'b1;
                        err_cause <= CAUSE_WINDOW;
                    end else if (left == '0) begin
                        phase <= PH_POLL;
                    end else begin
                        cur_sect <= cur_sect + 1'b1;
                        left     <= left - 1'b1;
                        phase    <= PH_SECT;
                    end
                end
                PH_POLL: begin
                    poll_cnt <= poll_cnt + 1'b1;
                    case (verdict)
                        VD_COMPLETE: begin
                            phase <= PH_IDLE;
                            done  <= 1'b1;
                        end
                        VD_DEVFAIL: begin
                            phase     <= PH_IDLE;
                            done      <= 1'b1;
                            err       <= 1'b1;
                            err_cause <= CAUSE_DEVICE;
                        end
                        VD_STALL: begin
                            phase     <= PH_IDLE;
                            done      <= 1'b1;
                            err       <= 1'b1;
                            err_cause <= CAUSE_STALL;
                        end
                        default: if (poll_cnt == POLL_W'(POLL_MAX - 1)) begin
                            phase     <= PH_IDLE;
                            done      <= 1'b1;
                            err       <= 1'b1;
                            err_cause <= CAUSE_TIMEOUT;
                        end
                    endcase
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Cycles since the most recent sector command, kept while queuing sectors
    always_ff @(posedge clk) begin
        if (rst || phase == PH_SECT || phase == PH_IDLE)
            win_cnt <= '0;
        else if (phase == PH_CHECK && win_cnt != WIN_W'(WIN_CYC))
            win_cnt <= win_cnt + 1'b1;
    end

    AST_SINGLE_BUS_OP: assert property (@(posedge clk) disable iff (rst)
        !(fl_we && fl_re)); // R1
    AST_TIMER_ABORT: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CHECK && fl_rdata[TIMER_BIT]) |=> (done && err && err_cause == CAUSE_WINDOW)); // R3
    AST_GAP_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SECT) |-> (win_cnt < WIN_W'(WIN_CYC) && win_cnt <= 1)); // R4
    AST_CLEAN_FINISH: assert property (@(posedge clk) disable iff (rst)
        (done && !err) |-> (err_cause == CAUSE_NONE)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
    AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done); // R9
    AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy) && !start) |=> $stable(err_cause)); // R9
endmodule

// File: tb/sim_nor_multi_erase.sv
module sim_nor_multi_erase;
    localparam int SECT_W    = 4;
    localparam int SECT_BITS = 12;
    localparam int CNT_W     = 5;
    localparam int POLL_MAX  = 40;
    localparam int ADDR_W    = SECT_W + SECT_BITS;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [SECT_W-1:0] start_sector = '0;
    logic [CNT_W-1:0]  sector_count = '0;
    logic              busy, done, err, fl_we, fl_re;
    logic [2:0]        err_cause;
    logic [ADDR_W-1:0] fl_addr;
    logic [7:0]        fl_wdata, fl_rdata;

    int nchk = 0;
    int nerr = 0;

    logic [7:0]  seq [0:31];
    int          rd_idx = 0;
    int          log_n  = 0;
    logic [24:0] log_q [0:63];
    logic        log_clr = 1'b0;

    always #10 clk = ~clk;

    nor_multi_erase #(
        .SECT_W(SECT_W), .SECT_BITS(SECT_BITS), .CNT_W(CNT_W),
        .WIN_CYC(2500), .POLL_MAX(POLL_MAX)
    ) u0 (
        .clk(clk), .rst(rst), .start(start), .start_sector(start_sector),
        .sector_count(sector_count), .busy(busy), .done(done), .err(err),
        .err_cause(err_cause), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_we(fl_we), .fl_re(fl_re), .fl_rdata(fl_rdata)
    );

    // Flash model: status bytes come from seq, then a toggling pattern
    assign fl_rdata = (rd_idx < 32) ? seq[rd_idx] : (rd_idx[0] ? 8'h40 : 8'h00);

    always @(posedge clk) begin
        if (log_clr) begin
            log_n  <= 0;
            rd_idx <= 0;
        end else if (!rst && (fl_we || fl_re)) begin
            if (log_n < 64)
                log_q[log_n] <= {fl_we, fl_addr, fl_we ? fl_wdata : 8'h00};
            log_n <= log_n + 1;
            if (fl_re)
                rd_idx <= rd_idx + 1;
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic clear_seq();
        for (int i = 0; i < 32; i++) seq[i] = 8'h00;
    endtask

    // One erase run; abort_j < 0 means no window abort, inj_at >= 0 pulses start while busy
    task automatic run_case(input string tag, input int n_sect, input int s, input int d,
                            input int abort_j, input int exp_cause, input int inj_at);
        logic [24:0] ex [0:63];
        int ne = 0;
        int last, exp_n, n, held_n;
        ex[ne++] = {1'b1, 16'h0555, 8'hF0};
        ex[ne++] = {1'b1, 16'h0555, 8'hAA};
        ex[ne++] = {1'b1, 16'h02AA, 8'h55};
        ex[ne++] = {1'b1, 16'h0555, 8'h80};
        ex[ne++] = {1'b1, 16'h0555, 8'hAA};
        ex[ne++] = {1'b1, 16'h02AA, 8'h55};
        last = (abort_j >= 0) ? abort_j : n_sect - 1;
        for (int i = 0; i <= last; i++) begin
            ex[ne++] = {1'b1, 16'((s + i) << SECT_BITS), 8'h30};
            if (i > 0) ex[ne++] = {1'b0, 16'((s + i) << SECT_BITS), 8'h00};
        end
        if (abort_j < 0)
            for (int k = 0; k <= d; k++) ex[ne++] = {1'b0, 16'(s << SECT_BITS), 8'h00};
        exp_n = (abort_j >= 0) ? 7 + 2 * abort_j : 6 + 2 * n_sect + d;

        @(negedge clk) log_clr = 1'b1;
        @(negedge clk) log_clr = 1'b0;
        start = 1'b1; start_sector = SECT_W'(s); sector_count = CNT_W'(n_sect);
        @(posedge clk); #5;
        start = 1'b0;
        n = 0;
        while (!done && n < 600) begin
            @(posedge clk); #5;
            n++;
            start = (n == inj_at);
            if (n == inj_at) begin start_sector = 4'd9; sector_count = 5'd3; end
            if (n == 1) check(busy === 1'b1, {tag, " R9 busy after start"}, busy, 1);
        end
        start = 1'b0;
        check(n == exp_n, {tag, " R11 done edge"}, n, exp_n);
        check(err === (exp_cause != 0), {tag, " R6/R7/R8 err flag"}, err, exp_cause != 0);
        check(err_cause == 3'(exp_cause), {tag, " R3/R6/R7/R8 cause"}, err_cause, exp_cause);
        check(log_n == ne, {tag, " R1/R2/R3/R5 bus cycle count"}, log_n, ne);
        for (int i = 0; i < ne && i < 64; i++)
            check(log_q[i] == ex[i], {tag, " R1/R2/R3/R5 bus cycle"}, log_q[i], ex[i]);
        held_n = log_n;
        @(posedge clk); #5;
        check(done === 1'b0, {tag, " R9 done pulse width"}, done, 0);
        check(busy === 1'b0, {tag, " R9 idle after done"}, busy, 0);
        repeat (3) @(posedge clk);
        #5;
        check(err_cause == 3'(exp_cause), {tag, " R9 cause held"}, err_cause, exp_cause);
        check(log_n == held_n, {tag, " R9 no bus activity after done"}, log_n, held_n);
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #5;
        check(fl_we === 1'b0 && fl_re === 1'b0, "R10 bus idle in reset", {fl_we, fl_re}, 0);
        @(negedge clk) rst = 1'b0;
        @(posedge clk); #5;
        check(busy === 1'b0 && done === 1'b0, "R10 busy/done after reset", {busy, done}, 0);
        check(err === 1'b0 && err_cause == 3'd0, "R10 err after reset", {err, err_cause}, 0);
        check(fl_we === 1'b0 && fl_re === 1'b0, "R10 bus idle after reset", {fl_we, fl_re}, 0);
    endtask

    task automatic test_single();   // R2 R7: completes on the fourth poll read
        clear_seq();
        seq[0] = 8'h40; seq[1] = 8'h00; seq[2] = 8'h40; seq[3] = 8'h80;
        run_case("single", 1, 3, 3, -1, 0, -1);
    endtask

    task automatic test_multi();    // R3 R4 R5: history fill must not decide early
        clear_seq();
        seq[2] = 8'h00; seq[3] = 8'h80; seq[4] = 8'h00; seq[5] = 8'h40; seq[6] = 8'hFF;
        run_case("multi", 3, 5, 4, -1, 0, -1);
    endtask

    task automatic test_window();   // R3: timer bit seen on the second check read
        clear_seq();
        seq[0] = 8'h00; seq[1] = 8'h08;
        run_case("window", 4, 0, 0, 2, 1, -1);
    endtask

    task automatic test_devfail();  // R6: bit 5 set in third-newest read
        clear_seq();
        seq[0] = 8'h24; seq[1] = 8'h44; seq[2] = 8'h44;
        run_case("devfail", 1, 7, 2, -1, 2, -1);
    endtask

    task automatic test_stall();    // R6: equal reads with bit 7 set still fail
        clear_seq();
        seq[0] = 8'h00; seq[1] = 8'h80; seq[2] = 8'h80;
        run_case("stall", 1, 1, 2, -1, 3, -1);
    endtask

    task automatic test_timeout();  // R8
        for (int i = 0; i < 32; i++) seq[i] = (i % 2 == 1) ? 8'h40 : 8'h00;
        run_case("timeout", 1, 4, POLL_MAX - 1, -1, 4, -1);
    endtask

    task automatic test_ignore();   // R9: start while busy does not restart
        clear_seq();
        seq[0] = 8'h00; seq[1] = 8'h40; seq[2] = 8'h00; seq[3] = 8'h40; seq[4] = 8'h00; seq[5] = 8'hC0;
        run_case("ignore", 1, 2, 5, -1, 0, 9);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        test_reset();
        test_single();
        test_multi();
        test_window();
        test_devfail();
        test_stall();
        test_timeout();
        test_ignore();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule